// File: doc/BRIEF.md
# Variable-Frequency Phase-Accumulator Generator

This block is a numerically controlled oscillator. A phase accumulator clocked by the fixed reference clock adds a step each cycle, wrapping modulo 2^16. The step comes from a 16-bit control word. Bit 15 of the accumulator is the square-wave output. A one-cycle tick marks each rising edge of that square wave, and a downstream PWM stage uses the tick as its clock enable. The output frequency is step × 2^-16 × Fref.

Software loads the control word one byte at a time. A high-byte write only stages the byte. A low-byte write joins the staged high byte with the new low byte and commits both at once to the active word. A half-written word therefore never reaches the accumulator. A start input runs the generator. While start is low, the accumulator is cleared and no tick is produced.

Control words of the form 2^k (1 up to 32768) give an exact 50% duty square wave. The downstream PWM stage relies on this.

Top module: `vf_nco`

## Requirements
- R1: After reset the active word, the staged high byte and the accumulator are zero, and wave_o and tick_o are low. Running with no word loaded leaves wave_o low.
- R2: The step is the active word when the word is below 0x8000. Otherwise the step is (0x10000 − word) mod 0x10000, so 0x8000 maps to 0x8000 and 0xFFFF maps to 1.
- R3: On every clock edge with en_i high, the accumulator gains the step modulo 2^16. wave_o equals accumulator bit 15 after that edge.
- R4: tick_o is high for exactly the cycles in which wave_o has just gone from 0 to 1. It is never high in two consecutive cycles.
- R5: A clock edge with en_i low clears the accumulator. From then on wave_o and tick_o are low, and the next enabled edge restarts from zero.
- R6: A high-byte write (hi_wr_i with lo_wr_i low) only updates the staged byte. It has no effect on the active word, so the output keeps its frequency.
- R7: A low-byte write makes the active word {staged high byte, byte_i} at that edge. The next edge already adds the new step. When both strobes are high in one cycle, the commit uses the previously staged high byte and byte_i becomes the new staged byte.
- R8: A word of 2^k gives a square wave with equal high and low runs of 2^(15−k) cycles each, starting from a cleared accumulator.
- R9: A word whose step is zero (0x0000) keeps the accumulator still and produces no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Start/run; low clears the accumulator |
| hi_wr_i | input | 1 | Stage byte_i as the high byte |
| lo_wr_i | input | 1 | Commit {staged high, byte_i} as the active word |
| byte_i | input | 8 | Control-word byte |
| wave_o | output | 1 | Square wave (accumulator MSB) |
| tick_o | output | 1 | One-cycle pulse on each rising edge of wave_o |

## Verification
The bench targets the boundary of the step decode:
- Words 0x8000, 0xC000 and 0xFFFF expose a decoder that negates at the wrong threshold or does not negate at all. Such a design would run at nearly the full rate where it should crawl, or the reverse.
- Staging a high byte in the middle of a run catches a loader that commits early, because the output period would change before the low-byte write.
- Writing both bytes in the same cycle catches a loader that merges the new byte into the commit.
- Dropping start in the middle of a period catches an accumulator that only freezes. Such a design would restart at the old phase and emit an early tick.
- Long runs with random words, random byte writes and random start gaps are compared edge by edge against a bench model. Power-of-two duty counts and a zero-step run round out the checks.

// File: rtl/vf_nco_pkg.sv
package vf_nco_pkg;
  typedef enum logic [1:0] {
    LD_NONE   = 2'b00,
    LD_STAGE  = 2'b01,
    LD_COMMIT = 2'b10,
    LD_BOTH   = 2'b11
  } ld_op_e;
endpackage

// File: rtl/vf_nco_word_load.sv
module vf_nco_word_load #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_wr_i,
  input  logic              lo_wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] stage_o,
  output logic [WORD_W-1:0] word_o
);
  import vf_nco_pkg::*;

  ld_op_e op;
  logic [BYTE_W-1:0] stage_q;
  logic [WORD_W-1:0] word_q;

  assign op = ld_op_e'({lo_wr_i, hi_wr_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      word_q  <= '0;
    end else begin
      unique case (op)
        LD_STAGE:  stage_q <= byte_i;
        LD_COMMIT: word_q  <= {stage_q, byte_i};
        LD_BOTH: begin
          // commit sees the old staged byte
          word_q  <= {stage_q, byte_i};
          stage_q <= byte_i;
        end
        default: ;
      endcase
    end
  end

  assign stage_o = stage_q;
  assign word_o  = word_q;
endmodule

// File: rtl/vf_nco_step_dec.sv
module vf_nco_step_dec #(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] step_o
);
  always_comb begin
    if (word_i[WORD_W-1]) step_o = (~word_i) + 1'b1;
    else                  step_o = word_i;
  end
endmodule

// File: rtl/vf_nco_accum.sv
module vf_nco_accum #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] step_i,
  output logic [WORD_W-1:0] acc_o,
  output logic              tick_o
);
  logic [WORD_W-1:0] acc_q, acc_nxt;
  logic              tick_q;

  assign acc_nxt = acc_q + step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_nxt;
      tick_q <= acc_nxt[WORD_W-1] & ~acc_q[WORD_W-1];
    end
  end

  assign acc_o  = acc_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/vf_nco.sv
module vf_nco #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hi_wr_i,
  input  logic              lo_wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              wave_o,
  output logic              tick_o
);
  logic [BYTE_W-1:0] stage_w;
  logic [WORD_W-1:0] word_w, step_w, acc_w;

  vf_nco_word_load #(.BYTE_W(BYTE_W)) i_load (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hi_wr_i (hi_wr_i),
    .lo_wr_i (lo_wr_i),
    .byte_i  (byte_i),
    .stage_o (stage_w),
    .word_o  (word_w)
  );

  vf_nco_step_dec #(.WORD_W(WORD_W)) i_dec (
    .word_i (word_w),
    .step_o (step_w)
  );

  vf_nco_accum #(.WORD_W(WORD_W)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .step_i (step_w),
    .acc_o  (acc_w),
    .tick_o (tick_o)
  );

  assign wave_o = acc_w[WORD_W-1];
endmodule

// File: rtl/vf_nco_chk.sv
module vf_nco_chk #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              hi_wr_i,
  input logic              lo_wr_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic              wave_o,
  input logic              tick_o,
  input logic [BYTE_W-1:0] stage,
  input logic [WORD_W-1:0] word,
  input logic [WORD_W-1:0] step,
  input logic [WORD_W-1:0] acc
);
  // R3
  acc_adds_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> acc == $past(acc) + $past(step));

  // R4
  tick_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_o && !$past(wave_o)) |-> tick_o);

  // R4
  tick_only_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (wave_o && !$past(wave_o)));

  // R4
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R5
  stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc == '0 && !wave_o && !tick_o));

  // R6
  stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr_i && !lo_wr_i) |=> ($stable(word) && stage == $past(byte_i)));

  // R7
  commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i |=> word == {$past(stage), $past(byte_i)});

  // R9
  zero_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == '0 && en_i) |=> (acc == $past(acc) && !tick_o));
endmodule

bind vf_nco vf_nco_chk #(.BYTE_W(BYTE_W)) u_vf_nco_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .hi_wr_i (hi_wr_i),
  .lo_wr_i (lo_wr_i),
  .byte_i  (byte_i),
  .wave_o  (wave_o),
  .tick_o  (tick_o),
  .stage   (stage_w),
  .word    (word_w),
  .step    (step_w),
  .acc     (acc_w)
);

// File: tb/test_vf_nco.sv
`timescale 1ns/1ps
module test_vf_nco;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       hi_wr_i = 1'b0;
  logic       lo_wr_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       wave_o, tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R3";

  logic [15:0] m_word = '0, m_acc = '0;
  logic [7:0]  m_stage = '0;
  logic        m_tick = 1'b0;

  always #4 clk_i = ~clk_i;

  vf_nco i_vf_nco (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .hi_wr_i(hi_wr_i),
    .lo_wr_i(lo_wr_i), .byte_i(byte_i), .wave_o(wave_o), .tick_o(tick_o)
  );

  function automatic logic [15:0] exp_step(input logic [15:0] w);
    return (w >= 16'h8000) ? 16'(17'h10000 - {1'b0, w}) : w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic en, input logic hw, input logic lw, input logic [7:0] b);
    logic [15:0] nxt;
    en_i = en; hi_wr_i = hw; lo_wr_i = lw; byte_i = b;
    @(posedge clk_i);
    if (!en) begin
      m_acc = '0; m_tick = 1'b0;
    end else begin
      nxt = m_acc + exp_step(m_word);
      m_tick = nxt[15] & ~m_acc[15];
      m_acc = nxt;
    end
    if (lw) m_word = {m_stage, b};
    if (hw) m_stage = b;
    @(negedge clk_i);
    check(cur_req, {31'd0, wave_o}, {31'd0, m_acc[15]});
    check(cur_req, {31'd0, tick_o}, {31'd0, m_tick});
  endtask

  task automatic load(input logic en, input logic [15:0] w);
    cyc(en, 1'b1, 1'b0, w[15:8]);
    cyc(en, 1'b0, 1'b1, w[7:0]);
  endtask

  task automatic stop_start();
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic duty(input logic [15:0] w, input int runlen);
    int hi_cnt, ticks;
    cur_req = "R8";
    load(1'b0, w);
    stop_start();
    hi_cnt = 0; ticks = 0;
    for (int i = 0; i < 8 * runlen; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 8'h00);
      hi_cnt += int'(wave_o);
      ticks  += int'(tick_o);
    end
    check("R8", hi_cnt, 4 * runlen);
    check("R8", ticks, 4);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ticks;
    void'($urandom(32'd2024));
    #3;
    // R1 outputs in reset
    check("R1", {31'd0, wave_o}, 32'd0);
    check("R1", {31'd0, tick_o}, 32'd0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 no word loaded: nothing moves
    cur_req = "R1";
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);

    // R8 power-of-two words
    duty(16'h8000, 1);
    duty(16'h4000, 2);
    duty(16'h1000, 8);
    duty(16'h0100, 128);

    // R2 decode boundary: 0xC000 behaves like 0x4000, 0xFFFF like 1
    cur_req = "R2";
    duty(16'hC000, 2);
    cur_req = "R2";
    load(1'b1, 16'hFFFF);
    stop_start();
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
    check("R2", {31'd0, wave_o}, 32'd0);
    load(1'b1, 16'h7FFF);
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);

    // R6 staging alone keeps the period
    cur_req = "R6";
    load(1'b1, 16'h2000);
    stop_start();
    ticks = 0;
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, (i % 5) == 0, 1'b0, 8'h80);
      ticks += int'(tick_o);
    end
    check("R6", ticks, 8);

    // R7 commit and same-cycle strobes
    cur_req = "R7";
    cyc(1'b1, 1'b1, 1'b0, 8'h12);
    cyc(1'b1, 1'b1, 1'b1, 8'h00);
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, 1'b0, 1'b1, 8'h34);
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);

    // R5 stop mid-period clears phase
    cur_req = "R5";
    load(1'b1, 16'h3000);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
    stop_start();
    check("R5", {31'd0, wave_o}, 32'd0);
    check("R5", {31'd0, tick_o}, 32'd0);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);

    // R9 zero step
    cur_req = "R9";
    load(1'b1, 16'h0000);
    ticks = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 8'h00);
      ticks += int'(tick_o);
    end
    check("R9", ticks, 0);

    // R3 R4 random words, writes and start gaps against the model
    cur_req = "R3";
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[7:0] != 8'h00, r[15:12] == 4'h0, r[19:16] == 4'h0, r[31:24]);
    end
    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(1'b1, r[10:8] == 3'd0, r[14:12] == 3'd0, r[31:24]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule